// File: doc/BRIEF.md
# Status-Polled Flash Bank Erase/Program Sequencer

This block runs a whole-bank erase or a whole-bank program on a byte-wide flash device that uses a status-register command set. A pulse on `start` launches the operation chosen by `op`. An erase sends a setup command and a confirm command to the bank base, then polls status until the device reports ready. A program takes each byte of the bank from an image source in ascending address order. For every byte it sends a setup command, waits a fixed settling time, writes the byte, and polls status.

Each operation, whether it completes or is cut short, ends with a clear-status command, then a reset-to-array command, then a read-back of every byte of the bank. For an erase the read-back must give the blank value everywhere. For a program it must match the image. `done` pulses once when the read-back finishes. `error` and `timeout` report the result and hold it until the next operation is accepted.

Top module: `flash_bank_seq`

## Requirements
- R1: `op`=0 selects erase. The erase begins with a write of 0x20 to bank address 0, followed directly by a write of 0xD0 to address 0, followed by status polling.
- R2: One poll iteration is a write of 0x70 to address 0 and then a read of address 0. Iterations repeat while bit 7 of the byte read is 0, and polling ends at the first byte with bit 7 set.
- R3: If POLL_LIMIT iterations in a row return bit 7 clear, polling stops. `timeout` and `error` are set and no further bytes are programmed.
- R4: Every operation, including one that was cut short, ends its write sequence with 0x50 and then 0xFF, both written to address 0.
- R5: After an erase, every bank address is read back. Any byte other than 0xFF sets `error`.
- R6: `op`=1 selects program. For each address from 0 to the last, the block writes 0x40 to that address, then writes the image byte to the same address exactly SETUP_WAIT+1 cycles later, then polls status. SETUP_WAIT is CLK_MHZ*SETUP_NS/1000 rounded up.
- R7: After a program, every bank address is read back and compared with the image byte at the same address. Any difference sets `error`.
- R8: A ready status byte that also has any of bits 5..3 (mask 0x38) set sets `error` and stops programming. `timeout` stays clear.
- R9: `done` is high for exactly one cycle per operation. `error` and `timeout` stay stable after `done` until the next accepted `start`, and they read 0 from the cycle after that start.
- R10: A `start` seen while an operation is in progress is ignored. It adds no bus writes and does not change the result.
- R11: Out of reset, `done`, `error`, `timeout`, `fl_we` and `fl_re` are low. `fl_we` and `fl_re` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Launch request, accepted only when idle |
| op | input | 1 | Operation select, 0 = erase, 1 = program |
| done | output | 1 | One-cycle completion pulse |
| error | output | 1 | Result of the last operation was a failure |
| timeout | output | 1 | Last operation hit the poll limit |
| fl_addr | output | AW | Flash byte address within the bank |
| fl_wdata | output | 8 | Flash write data or command byte |
| fl_we | output | 1 | Flash write strobe |
| fl_re | output | 1 | Flash read strobe; data is returned the next cycle |
| fl_rdata | input | 8 | Flash read data |
| img_addr | output | AW | Image source address |
| img_data | input | 8 | Image byte, valid one cycle after `img_addr` |

## Verification
Completion and acceptance can fall in the same cycle. The `done` pulse of one operation can coincide with the `start` of the next, and the old result must still be readable on `error` and `timeout` in that cycle before the new start clears them. The bench provokes this by sampling `done` with a result of error plus timeout and raising `start` in that same cycle. It then judges that the old flags were visible alongside `done`, that both read 0 one cycle later, and that the new operation produces exactly its own expected write sequence.

// File: rtl/fsq_pkg.sv
package fsq_pkg;

  localparam int BYTE_W = 8;

  localparam logic [7:0] CMD_ERASE_SETUP = 8'h20;
  localparam logic [7:0] CMD_ERASE_GO    = 8'hD0;
  localparam logic [7:0] CMD_PROG_SETUP  = 8'h40;
  localparam logic [7:0] CMD_STATUS      = 8'h70;
  localparam logic [7:0] CMD_CLR_STATUS  = 8'h50;
  localparam logic [7:0] CMD_ARRAY       = 8'hFF;
  localparam logic [7:0] STAT_FAULT_MASK = 8'h38;
  localparam logic [7:0] BLANK_BYTE      = 8'hFF;

  typedef enum logic [3:0] {
    S_IDLE, S_ER_SETUP, S_ER_GO, S_PG_SETUP, S_PG_WAIT, S_PG_DATA,
    S_POLL_CMD, S_POLL_RD, S_POLL_CHK, S_TAIL_CLR, S_TAIL_RST,
    S_VF_RD, S_VF_CHK
  } fsq_state_e;

  function automatic int wait_cycles(input int mhz, input int ns);
    int c;
    c = (mhz * ns + 999) / 1000;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic logic stat_ready(input logic [7:0] s);
    return s[7];
  endfunction

  function automatic logic stat_fault(input logic [7:0] s);
    return s[7] && ((s & STAT_FAULT_MASK) != 8'h00);
  endfunction

  function automatic logic [7:0] verify_expect(input logic is_prog, input logic [7:0] img);
    return is_prog ? img : BLANK_BYTE;
  endfunction

endpackage

// File: rtl/fsq_delay.sv
module fsq_delay #(
  parameter int CYCLES = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic run,
  output logic expired
);
  localparam int CW = (CYCLES < 2) ? 1 : $clog2(CYCLES + 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  cnt <= '0;
    else if (load)               cnt <= CW'(CYCLES - 1);
    else if (run && cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign expired = run && (cnt == '0);
endmodule

// File: rtl/fsq_poll_ctr.sv
module fsq_poll_ctr #(
  parameter int LIMIT = 1000000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic step,
  output logic last
);
  localparam int CW = (LIMIT < 2) ? 1 : $clog2(LIMIT + 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt <= '0;
    else if (clr)   cnt <= '0;
    else if (step)  cnt <= cnt + 1'b1;
  end

  assign last = (cnt == CW'(LIMIT - 1));
endmodule

// File: rtl/flash_bank_seq.sv
module flash_bank_seq
  import fsq_pkg::*;
#(
  parameter int AW         = 13,
  parameter int CLK_MHZ    = 100,
  parameter int SETUP_NS   = 1000,
  parameter int POLL_LIMIT = 1000000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          op,
  output logic          done,
  output logic          error,
  output logic          timeout,
  output logic [AW-1:0] fl_addr,
  output logic [7:0]    fl_wdata,
  output logic          fl_we,
  output logic          fl_re,
  input  logic [7:0]    fl_rdata,
  output logic [AW-1:0] img_addr,
  input  logic [7:0]    img_data
);
  localparam int SETUP_WAIT = wait_cycles(CLK_MHZ, SETUP_NS);

  fsq_state_e    state, nxt;
  logic [AW-1:0] idx;
  logic          op_q, done_q, err_q, tmo_q;

  // named internal events
  logic op_accept, idx_last, setup_wr, data_wr, wait_over;
  logic poll_begin, poll_step, poll_last, st_ready, st_fault;
  logic poll_giveup, byte_fault, verify_miss, tail_clr_now, verify_end;

  assign op_accept    = (state == S_IDLE) && start;
  assign idx_last     = (idx == '1);
  assign setup_wr     = (state == S_PG_SETUP);
  assign data_wr      = (state == S_PG_DATA);
  assign poll_begin   = (state == S_ER_GO) || data_wr;
  assign st_ready     = stat_ready(fl_rdata);
  assign st_fault     = stat_fault(fl_rdata);
  assign poll_step    = (state == S_POLL_CHK) && !st_ready;
  assign poll_giveup  = poll_step && poll_last;
  assign byte_fault   = (state == S_POLL_CHK) && st_fault;
  assign verify_miss  = (state == S_VF_CHK) && (fl_rdata != verify_expect(op_q, img_data));
  assign tail_clr_now = (state == S_TAIL_CLR);
  assign verify_end   = (state == S_VF_CHK) && idx_last;

  fsq_delay #(.CYCLES(SETUP_WAIT)) u_delay (
    .clk(clk), .rst_n(rst_n), .load(setup_wr),
    .run(state == S_PG_WAIT), .expired(wait_over)
  );

  fsq_poll_ctr #(.LIMIT(POLL_LIMIT)) u_poll (
    .clk(clk), .rst_n(rst_n), .clr(poll_begin),
    .step(poll_step), .last(poll_last)
  );

  always_comb begin
    nxt = state;
    unique case (state)
      S_IDLE:     if (start) nxt = op ? S_PG_SETUP : S_ER_SETUP;
      S_ER_SETUP: nxt = S_ER_GO;
      S_ER_GO:    nxt = S_POLL_CMD;
      S_PG_SETUP: nxt = S_PG_WAIT;
      S_PG_WAIT:  if (wait_over) nxt = S_PG_DATA;
      S_PG_DATA:  nxt = S_POLL_CMD;
      S_POLL_CMD: nxt = S_POLL_RD;
      S_POLL_RD:  nxt = S_POLL_CHK;
      S_POLL_CHK: begin
        if (!st_ready)                         nxt = poll_last ? S_TAIL_CLR : S_POLL_CMD;
        else if (st_fault || !op_q || idx_last) nxt = S_TAIL_CLR;
        else                                   nxt = S_PG_SETUP;
      end
      S_TAIL_CLR: nxt = S_TAIL_RST;
      S_TAIL_RST: nxt = S_VF_RD;
      S_VF_RD:    nxt = S_VF_CHK;
      S_VF_CHK:   nxt = idx_last ? S_IDLE : S_VF_RD;
      default:    nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      idx    <= '0;
      op_q   <= 1'b0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
      tmo_q  <= 1'b0;
    end else begin
      state  <= nxt;
      done_q <= verify_end;
      if (op_accept) begin
        op_q  <= op;
        idx   <= '0;
        err_q <= 1'b0;
        tmo_q <= 1'b0;
      end else begin
        if (poll_giveup) begin
          err_q <= 1'b1;
          tmo_q <= 1'b1;
        end
        if (byte_fault || verify_miss) err_q <= 1'b1;
        if (state == S_POLL_CHK && st_ready && !st_fault && op_q && !idx_last)
          idx <= idx + 1'b1;
        else if (state == S_TAIL_RST)
          idx <= '0;
        else if (state == S_VF_CHK && !idx_last)
          idx <= idx + 1'b1;
      end
    end
  end

  always_comb begin
    fl_we    = 1'b0;
    fl_re    = 1'b0;
    fl_addr  = '0;
    fl_wdata = 8'h00;
    unique case (state)
      S_ER_SETUP: begin fl_we = 1'b1; fl_wdata = CMD_ERASE_SETUP; end
      S_ER_GO:    begin fl_we = 1'b1; fl_wdata = CMD_ERASE_GO; end
      S_PG_SETUP: begin fl_we = 1'b1; fl_addr = idx; fl_wdata = CMD_PROG_SETUP; end
      S_PG_DATA:  begin fl_we = 1'b1; fl_addr = idx; fl_wdata = img_data; end
      S_POLL_CMD: begin fl_we = 1'b1; fl_wdata = CMD_STATUS; end
      S_POLL_RD:  fl_re = 1'b1;
      S_TAIL_CLR: begin fl_we = 1'b1; fl_wdata = CMD_CLR_STATUS; end
      S_TAIL_RST: begin fl_we = 1'b1; fl_wdata = CMD_ARRAY; end
      S_VF_RD:    begin fl_re = 1'b1; fl_addr = idx; end
      default: ;
    endcase
  end

  assign img_addr = idx;
  assign done     = done_q;
  assign error    = err_q;
  assign timeout  = tmo_q;
endmodule

// File: rtl/fsq_checker.sv
module fsq_checker #(
  parameter int AW       = 13,
  parameter int CLK_MHZ  = 100,
  parameter int SETUP_NS = 1000
) (
  input logic          clk,
  input logic          rst_n,
  input logic          done,
  input logic          error,
  input logic          timeout,
  input logic          fl_we,
  input logic          fl_re,
  input logic [AW-1:0] fl_addr,
  input logic [7:0]    fl_wdata,
  input logic          op_accept,
  input logic          setup_wr,
  input logic          data_wr,
  input logic          tail_clr_now
);
  localparam int GAP_NEED = fsq_pkg::wait_cycles(CLK_MHZ, SETUP_NS);

  logic [31:0] gap_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     gap_cnt <= '0;
    else if (setup_wr)              gap_cnt <= '0;
    else if (gap_cnt != 32'hFFFF_FFFF) gap_cnt <= gap_cnt + 1;
  end

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_flags_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    op_accept |=> (!error && !timeout));
  assert_timeout_is_error_R3: assert property (@(posedge clk) disable iff (!rst_n)
    timeout |-> error);
  assert_strobe_excl_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(fl_we && fl_re));
  assert_tail_order_R4: assert property (@(posedge clk) disable iff (!rst_n)
    tail_clr_now |=> (fl_we && fl_wdata == 8'hFF && fl_addr == '0));
  assert_setup_gap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    data_wr |-> (gap_cnt >= 32'(GAP_NEED)));
  assert_done_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!fl_we && !fl_re));
endmodule

bind flash_bank_seq fsq_checker #(
  .AW(AW), .CLK_MHZ(CLK_MHZ), .SETUP_NS(SETUP_NS)
) chk_i (
  .clk(clk), .rst_n(rst_n), .done(done), .error(error), .timeout(timeout),
  .fl_we(fl_we), .fl_re(fl_re), .fl_addr(fl_addr), .fl_wdata(fl_wdata),
  .op_accept(op_accept), .setup_wr(setup_wr), .data_wr(data_wr),
  .tail_clr_now(tail_clr_now)
);

// File: tb/flash_bank_seq_tb.sv
module flash_bank_seq_tb_top;
  localparam int AW    = 6;
  localparam int BANK  = 1 << AW;
  localparam int LIMIT = 12;
  localparam int WAITC = 100;   // 100 MHz * 1000 ns
  localparam int BUSY  = 2;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, op = 1'b0;
  logic done, error, timeout, fl_we, fl_re;
  logic [AW-1:0] fl_addr, img_addr;
  logic [7:0] fl_wdata, fl_rdata, img_data;

  int checks = 0, fails = 0;

  always #5 clk = ~clk;

  flash_bank_seq #(.AW(AW), .CLK_MHZ(100), .SETUP_NS(1000), .POLL_LIMIT(LIMIT)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op), .done(done),
    .error(error), .timeout(timeout), .fl_addr(fl_addr), .fl_wdata(fl_wdata),
    .fl_we(fl_we), .fl_re(fl_re), .fl_rdata(fl_rdata),
    .img_addr(img_addr), .img_data(img_data)
  );

  // image source, one cycle latency
  logic [7:0] img_mem [BANK];
  always @(posedge clk) img_data <= img_mem[img_addr];

  // flash device model
  logic [7:0] fmem [BANK];
  int  fmode = 0;          // 0 array, 1 status, 2 erase armed, 3 program armed
  int  busy_left = 0;
  bit  stuck = 0, corrupt_en = 0;
  int  corrupt_at = 5;
  logic [7:0] err_inject = 8'h00;

  always @(posedge clk) begin
    if (fl_we) begin
      if (fmode == 3) begin
        fmem[fl_addr] <= (corrupt_en && int'(fl_addr) == corrupt_at) ? (fl_wdata ^ 8'h01) : fl_wdata;
        busy_left <= BUSY;
        fmode <= 0;
      end else if (fmode == 2 && fl_wdata == 8'hD0) begin
        for (int i = 0; i < BANK; i++)
          fmem[i] <= (corrupt_en && i == corrupt_at) ? 8'hFE : 8'hFF;
        busy_left <= BUSY;
        fmode <= 1;
      end else begin
        case (fl_wdata)
          8'h20:   fmode <= 2;
          8'h40:   fmode <= 3;
          8'h70:   fmode <= 1;
          8'hFF:   fmode <= 0;
          default: ;
        endcase
      end
    end
    if (fl_re) begin
      if (fmode == 1) begin
        if (stuck) fl_rdata <= 8'h00;
        else if (busy_left > 0) begin
          fl_rdata <= 8'h00;
          busy_left <= busy_left - 1;
        end else fl_rdata <= 8'h80 | err_inject;
      end else fl_rdata <= fmem[fl_addr];
    end
  end

  // scoreboard
  logic [AW+7:0] exp_q [$];

  task automatic check(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && fl_we) begin
      if (exp_q.size() == 0) begin
        check(0, "R10 unexpected write", int'({fl_addr, fl_wdata}), 0);
      end else begin
        logic [AW+7:0] e;
        e = exp_q.pop_front();
        check({fl_addr, fl_wdata} == e, "R1/R2/R4/R6 write sequence",
              int'({fl_addr, fl_wdata}), int'(e));
      end
    end
  end

  task automatic exp_wr(input int a, input logic [7:0] d);
    exp_q.push_back({AW'(a), d});
  endtask
  task automatic exp_polls(input int n);
    for (int i = 0; i < n; i++) exp_wr(0, 8'h70);
  endtask
  task automatic exp_tail();
    exp_wr(0, 8'h50); exp_wr(0, 8'hFF);
  endtask
  task automatic exp_erase(input int polls);
    exp_wr(0, 8'h20); exp_wr(0, 8'hD0); exp_polls(polls); exp_tail();
  endtask
  task automatic exp_prog_full();
    for (int i = 0; i < BANK; i++) begin
      exp_wr(i, 8'h40); exp_wr(i, img_mem[i]); exp_polls(BUSY + 1);
    end
    exp_tail();
  endtask

  task automatic pulse_start(input logic o);
    @(negedge clk); start = 1'b1; op = o;
    @(negedge clk); start = 1'b0;
  endtask
  task automatic wait_done();
    do @(negedge clk); while (!done);
  endtask
  task automatic clear_knobs();
    stuck = 0; corrupt_en = 0; err_inject = 8'h00;
  endtask
  task automatic check_result(input string req, input bit e, input bit t);
    check(error == e, {req, " error"}, int'(error), int'(e));
    check(timeout == t, {req, " timeout"}, int'(timeout), int'(t));
    check(exp_q.size() == 0, {req, " leftover writes"}, exp_q.size(), 0);
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", fails, checks);
  endtask

  initial begin
    repeat (400000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    summary();
    $finish;
  end

  initial begin
    for (int i = 0; i < BANK; i++) begin
      img_mem[i] = 8'((i * 37 + 5) & 8'hFF);
      fmem[i] = 8'h00;
    end
    repeat (3) @(negedge clk);
    // R11 reset state
    check(!done && !error && !timeout, "R11 reset flags", int'({done, error, timeout}), 0);
    check(!fl_we && !fl_re, "R11 reset strobes", int'({fl_we, fl_re}), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R1 R2 R4 R5 clean erase
    exp_erase(BUSY + 1);
    pulse_start(1'b0); wait_done();
    check_result("R1 R5 clean erase", 0, 0);
    @(negedge clk);
    check(!done, "R9 done one cycle", int'(done), 0);

    // R5 erase read-back finds a non-blank byte
    corrupt_en = 1;
    exp_erase(BUSY + 1);
    pulse_start(1'b0); wait_done();
    check_result("R5 erase verify", 1, 0);
    clear_knobs();

    // R6 clean program with setup gap measurement
    exp_prog_full();
    pulse_start(1'b1);
    begin
      int gap;
      while (!fl_we) @(negedge clk);
      gap = 0;
      do begin @(negedge clk); gap++; end while (!fl_we);
      check(gap == WAITC + 1, "R6 setup to data gap", gap, WAITC + 1);
    end
    wait_done();
    check_result("R6 R7 clean program", 0, 0);

    // R7 program read-back mismatch
    corrupt_en = 1;
    exp_prog_full();
    pulse_start(1'b1); wait_done();
    check_result("R7 program verify", 1, 0);
    clear_knobs();
    // R9 result held while idle
    repeat (10) @(negedge clk);
    check(error && !done, "R9 error held", int'({error, done}), 2);

    // R10 start during a running erase is ignored
    exp_erase(BUSY + 1);
    pulse_start(1'b0);
    check(!error, "R9 error cleared after start", int'(error), 0);
    repeat (4) @(negedge clk);
    pulse_start(1'b1);
    wait_done();
    check_result("R10 busy start ignored", 0, 0);

    // R3 erase timeout
    stuck = 1;
    exp_erase(LIMIT);
    pulse_start(1'b0); wait_done();
    check_result("R3 erase timeout", 1, 1);

    // Collision: start in the done cycle, old flags visible with done
    clear_knobs();
    exp_erase(BUSY + 1);
    check(done && error && timeout, "R9 flags with done", int'({done, error, timeout}), 7);
    start = 1'b1; op = 1'b0;
    @(negedge clk); start = 1'b0;
    check(!error && !timeout && !done, "R9 cleared by start in done cycle",
          int'({error, timeout, done}), 0);
    wait_done();
    check_result("R9 back-to-back erase", 0, 0);

    // R3 program timeout stops after the first byte
    stuck = 1;
    exp_wr(0, 8'h40); exp_wr(0, img_mem[0]); exp_polls(LIMIT); exp_tail();
    pulse_start(1'b1); wait_done();
    check_result("R3 R4 program timeout", 1, 1);
    clear_knobs();

    // R8 ready status with fault bit stops programming
    err_inject = 8'h10;
    exp_wr(0, 8'h40); exp_wr(0, img_mem[0]); exp_polls(BUSY + 1); exp_tail();
    pulse_start(1'b1); wait_done();
    check_result("R8 status fault", 1, 0);
    clear_knobs();

    repeat (3) @(negedge clk);
    check(exp_q.size() == 0, "R10 no stray writes", exp_q.size(), 0);
    summary();
    $finish;
  end
endmodule